// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is one DMA channel. A host programs five 32-bit registers through a small word-addressed window: source address, destination address, next-descriptor pointer, control and configuration. Once the channel is enabled and not halted, it copies data one element at a time over a simple memory master port. Each element is a read from the source address followed by a write of the same data to the destination address.

A flow type in the configuration register decides whether each element first waits for peripheral request lines. The control register holds a 12-bit element count, which drops by one per element. When the count runs out, the channel does one of two things. If the next pointer is non-zero, it fetches a four-word descriptor from memory and continues. Otherwise it clears its own enable bit. On completion it can emit a terminal-count pulse. A flow type the channel does not support produces an error pulse instead of a transfer.

Top module: `llx_dma_chan`

## Requirements
- R1: Host window word index 0 holds source address, 1 destination address, 2 next pointer, 3 control, 4 configuration. Each reads back what was last written. Indices 5 to 7 read zero and writes to them change nothing. All registers are zero after reset.
- R2: The channel starts an element only while configuration bit 0 (enable) is 1 and bit 18 (halt) is 0. While that does not hold, no memory request is issued.
- R3: The flow type is configuration bits [13:11]. The source peripheral index is bits [5:1] and the destination peripheral index is bits [10:6]. A request line is the OR of its single and burst inputs. Type 0 moves without waiting, type 1 needs the destination line, type 2 needs the source line, and type 3 needs both.
- R4: An element is one read at the source address, then one write of the returned data at the destination address. The request keeps its address, direction and write data steady until granted. Read data arrives with mem_rvalid after the grant.
- R5: Control bits [11:0] are the remaining count. It drops by one when an element's write is granted. A count of zero starts no element.
- R6: Control bit 26 makes the source address advance by 2^(bits [20:18]) bytes per element. Bit 27 makes the destination advance by 2^(bits [23:21]) bytes. mem_size carries the width code of the current access.
- R7: When the count reaches zero and the next pointer is non-zero, the channel reads pointer+0, +4, +12, +8 in that order. These load source, destination, control and then the new next pointer, and transfers continue from the loaded values.
- R8: When the count reaches zero and the next pointer is zero, configuration bit 0 is cleared.
- R9: tc_irq is a one-cycle pulse in the cycle after the final write is granted. It appears only if bit 31 of the control word that just finished is 1.
- R10: With flow type 4 to 7 while enabled, the channel makes no memory access. It raises err_irq for one cycle and clears configuration bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| sreq | input | PERIPHS | Single request lines per peripheral |
| breq | input | PERIPHS | Burst request lines per peripheral |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_size | output | 3 | Width code, 2^n bytes |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tc_irq | output | 1 | Terminal-count pulse |
| err_irq | output | 1 | Unsupported-flow error pulse |

## Verification
The bench sweeps width, count, increment enables and grant stall rates. It checks the final addresses and the exact number of memory accesses. A design that stepped by the wrong width, or issued an extra or missing access, shows up as a wrong address or access count. Every flow type is run against every combination of request lines, driven through both the single and the burst inputs, so a swapped peripheral index or a missing OR of the two inputs shows up as a moved or stuck element. The descriptor fetch order is captured from the read addresses: a sequential fetch, or one that updates the pointer before the control word, reads the wrong words. Halt, zero count and the unsupported flow types are checked to produce no access, and tc_irq is counted to catch a design that tests the reloaded control word instead of the finished one.

// File: rtl/llx_dma_chan.sv
module llx_dma_chan #(
  parameter int PERIPHS = 16,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [2:0]         host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic [PERIPHS-1:0] sreq,
  input  logic [PERIPHS-1:0] breq,
  output logic               mem_req,
  output logic               mem_we,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_wdata,
  output logic [2:0]         mem_size,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  output logic               tc_irq,
  output logic               err_irq
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_RDW, S_WR, S_LL, S_LLW} st_t;

  st_t         st;
  logic [31:0] src_q, dst_q, lli_q, ctl_q, cfg_q, buf_q;
  logic [1:0]  lidx;
  logic        tc_q, err_q;
  logic [31:0] req_pad;
  logic [31:0] ll_off;
  logic        go;

  wire             run   = cfg_q[0] & ~cfg_q[18];
  wire [2:0]       flow  = cfg_q[13:11];
  wire [4:0]       sid   = cfg_q[5:1];
  wire [4:0]       did   = cfg_q[10:6];
  wire [CNT_W-1:0] cnt   = ctl_q[CNT_W-1:0];
  wire [2:0]       sw    = ctl_q[20:18];
  wire [2:0]       dw    = ctl_q[23:21];
  wire [31:0]      sstep = 32'd1 << sw;
  wire [31:0]      dstep = 32'd1 << dw;
  wire             sr    = req_pad[sid];
  wire             dr    = req_pad[did];
  wire             last  = (cnt == CNT_W'(1));

  always_comb begin
    req_pad = '0;
    for (int i = 0; i < PERIPHS; i++) req_pad[i] = sreq[i] | breq[i];
  end

  always_comb begin
    case (flow)
      3'd0:    go = 1'b1;
      3'd1:    go = dr;
      3'd2:    go = sr;
      3'd3:    go = sr & dr;
      default: go = 1'b0;
    endcase
  end

  always_comb begin
    case (lidx)
      2'd0: ll_off = 32'd0;
      2'd1: ll_off = 32'd4;
      2'd2: ll_off = 32'd12;
      default: ll_off = 32'd8;
    endcase
  end

  assign mem_req   = (st == S_RD) || (st == S_WR) || (st == S_LL);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? dst_q : (st == S_LL) ? lli_q + ll_off : src_q;
  assign mem_wdata = buf_q;
  assign mem_size  = (st == S_WR) ? dw : (st == S_LL) ? 3'd2 : sw;
  assign tc_irq    = tc_q;
  assign err_irq   = err_q;

  always_comb begin
    case (host_addr)
      3'd0: host_rdata = src_q;
      3'd1: host_rdata = dst_q;
      3'd2: host_rdata = lli_q;
      3'd3: host_rdata = ctl_q;
      3'd4: host_rdata = cfg_q;
      default: host_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      src_q <= '0;
      dst_q <= '0;
      lli_q <= '0;
      ctl_q <= '0;
      cfg_q <= '0;
      buf_q <= '0;
      lidx  <= '0;
      tc_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      tc_q  <= 1'b0;
      err_q <= 1'b0;
      case (st)
        S_IDLE: if (run) begin
          if (flow[2]) begin
            err_q    <= 1'b1;
            cfg_q[0] <= 1'b0;
          end else if ((cnt != '0) && go) begin
            st <= S_RD;
          end
        end
        S_RD: if (mem_gnt) st <= S_RDW;
        S_RDW: if (mem_rvalid) begin
          buf_q <= mem_rdata;
          st    <= S_WR;
        end
        S_WR: if (mem_gnt) begin
          if (ctl_q[26]) src_q <= src_q + sstep;
          if (ctl_q[27]) dst_q <= dst_q + dstep;
          ctl_q[CNT_W-1:0] <= cnt - CNT_W'(1);
          st <= S_IDLE;
          if (last) begin
            tc_q <= ctl_q[31];
            if (lli_q != 32'd0) begin
              st   <= S_LL;
              lidx <= 2'd0;
            end else begin
              cfg_q[0] <= 1'b0;
            end
          end
        end
        S_LL: if (mem_gnt) st <= S_LLW;
        S_LLW: if (mem_rvalid) begin
          case (lidx)
            2'd0: src_q <= mem_rdata;
            2'd1: dst_q <= mem_rdata;
            2'd2: ctl_q <= mem_rdata;
            default: lli_q <= mem_rdata;
          endcase
          if (lidx == 2'd3) st <= S_IDLE;
          else begin
            lidx <= lidx + 2'd1;
            st   <= S_LL;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (host_we) begin
        case (host_addr)
          3'd0: src_q <= host_wdata;
          3'd1: dst_q <= host_wdata;
          3'd2: lli_q <= host_wdata;
          3'd3: ctl_q <= host_wdata;
          3'd4: cfg_q <= host_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/llx_dma_chan_chk.sv
module llx_dma_chan_chk #(
  parameter int CNT_W = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_gnt,
  input logic        mem_rvalid,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        tc_irq,
  input logic        err_irq,
  input logic [31:0] cfg_q,
  input logic [31:0] ctl_q
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !host_we) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_gnt && !host_we) |=> (ctl_q[CNT_W-1:0] == $past(ctl_q[CNT_W-1:0]) - CNT_W'(1)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && !mem_rvalid && !cfg_q[0]) |=> !mem_req);

  // R9
  tc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq |=> !tc_irq);

  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq);

  // R10
  err_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq && !$past(host_we)) |-> !cfg_q[0]);
endmodule

bind llx_dma_chan llx_dma_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .mem_req(mem_req), .mem_we(mem_we),
  .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .tc_irq(tc_irq), .err_irq(err_irq), .cfg_q(cfg_q), .ctl_q(ctl_q)
);

// File: tb/sim_llx_dma_chan.sv
`timescale 1ns/1ps
module sim_llx_dma_chan;
  localparam int P = 16;
  logic clk = 0, rst_n = 0;
  logic host_we = 0;
  logic [2:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic [P-1:0] sreq = 0, breq = 0;
  logic mem_req, mem_we, tc_irq, err_irq;
  logic [31:0] mem_addr, mem_wdata;
  logic [2:0] mem_size;
  logic mem_gnt = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;

  llx_dma_chan #(.PERIPHS(P)) u0 (.*);

  always #2.5 clk = ~clk;

  logic [31:0] mem [256];
  int tick = 0, stall = 0, acc_n = 0, tc_n = 0, err_n = 0, rn = 0;
  logic [31:0] rlog [64];
  logic [2:0] wsize = 0;
  logic pend = 0;
  int pa = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(negedge clk) begin
    tick++;
    if (tc_irq) tc_n++;
    if (err_irq) err_n++;
    mem_rvalid = 0;
    if (pend) begin mem_rvalid = 1; mem_rdata = mem[pa]; pend = 0; end
    mem_gnt = mem_req && (tick % (stall + 1) == 0);
    if (mem_gnt) begin
      acc_n++;
      if (mem_we) begin mem[(mem_addr >> 2) & 255] = mem_wdata; wsize = mem_size; end
      else begin pend = 1; pa = int'((mem_addr >> 2) & 255); rlog[rn % 64] = mem_addr; rn++; end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); host_addr = a; #1 v = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd4, v);
      if (!v[0]) break;
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l, input logic [31:0] c);
    wr(3'd0, s); wr(3'd1, d); wr(3'd2, l); wr(3'd3, c);
  endtask

  initial begin
    logic [31:0] v;
    int a0, t0, e0, run;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R1 reset reg", v, 0); end
    chk("R1 reset outputs", {29'd0, mem_req, tc_irq, err_irq}, 0);
    // R1 window readback
    for (int a = 0; a < 8; a++) wr(3'(a), 32'h5A00_0000 + 32'(a * 32'h111) & 32'hFFFF_FFFE);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 readback", v, a < 5 ? (32'h5A00_0000 + 32'(a * 32'h111) & 32'hFFFF_FFFE) : 32'd0);
    end
    wr(3'd4, 0);
    // R2 enable clear with nonzero count: nothing moves
    a0 = acc_n;
    setup(32'h40, 32'h100, 0, 32'd3);
    idle(20);
    chk("R2 disabled no access", 32'(acc_n - a0), 0);

    // R4 R5 R6 R8 R9 copy sweep
    run = 0;
    for (int w = 0; w < 3; w++)
      for (int n = 1; n <= 4; n++)
        for (int s = 0; s < 3; s++)
          for (int im = 0; im < 4; im++) begin
            logic si, di, tb;
            si = im[0]; di = im[1]; tb = run[0];
            stall = s;
            for (int k = 0; k < 16; k++) begin mem[16 + k] = 32'hA000_0000 + 32'(run * 16 + k); mem[64 + k] = 0; end
            setup(32'h40, 32'h100, 0,
                  {tb, 3'b000, di, si, 2'b00, 3'(w), 3'(w), 6'd0, 12'(n)});
            a0 = acc_n; t0 = tc_n;
            wr(3'd4, 32'd1);
            wait_idle();
            idle(2);
            rd(3'd3, v); chk("R5 count zero", {20'd0, v[11:0]}, 0);
            rd(3'd4, v); chk("R8 enable cleared", {31'd0, v[0]}, 0);
            rd(3'd0, v); chk("R6 src addr", v, 32'h40 + (si ? 32'(n << w) : 0));
            rd(3'd1, v); chk("R6 dst addr", v, 32'h100 + (di ? 32'(n << w) : 0));
            chk("R6 mem_size", {29'd0, wsize}, 32'(w));
            chk("R4 access count", 32'(acc_n - a0), 32'(2 * n));
            chk("R9 tc pulses", 32'(tc_n - t0), {31'd0, tb});
            if (w == 2) begin
              if (di)
                for (int k = 0; k < n; k++)
                  chk("R4 copied data", mem[64 + k], 32'hA000_0000 + 32'(run * 16 + (si ? k : 0)));
              else
                chk("R4 copied data", mem[64], 32'hA000_0000 + 32'(run * 16 + (si ? n - 1 : 0)));
            end
            run++;
          end
    stall = 0;

    // R3 flow gating
    for (int f = 1; f <= 3; f++)
      for (int p = 0; p < 4; p++)
        for (int via = 0; via < 2; via++) begin
          logic [P-1:0] lines;
          bit mv;
          lines = '0;
          if (p[0]) lines[3] = 1;
          if (p[1]) lines[9] = 1;
          if (via == 0) sreq = lines; else breq = lines;
          mv = (f == 1) ? p[1] : (f == 2) ? p[0] : (p[0] & p[1]);
          setup(32'h40, 32'h100, 0, {8'd0, 3'd2, 3'd2, 6'd0, 12'd1});
          wr(3'd4, 32'd1 | (32'd3 << 1) | (32'd9 << 6) | (32'(f) << 11));
          idle(30);
          rd(3'd3, v);
          chk("R3 flow gate", {20'd0, v[11:0]}, mv ? 0 : 1);
          wr(3'd4, 0);
          sreq = 0; breq = 0;
        end

    // R2 halt
    setup(32'h40, 32'h100, 0, {8'd0, 3'd2, 3'd2, 6'd0, 12'd2});
    a0 = acc_n;
    wr(3'd4, 32'd1 | (32'd1 << 18));
    idle(30);
    chk("R2 halted no access", 32'(acc_n - a0), 0);
    rd(3'd3, v); chk("R2 halted count", {20'd0, v[11:0]}, 2);
    wr(3'd4, 32'd1);
    wait_idle();
    rd(3'd3, v); chk("R2 resumed count", {20'd0, v[11:0]}, 0);

    // R5 zero count enabled
    setup(32'h40, 32'h100, 0, 32'd0);
    a0 = acc_n;
    wr(3'd4, 32'd1);
    idle(20);
    chk("R5 zero count no access", 32'(acc_n - a0), 0);
    rd(3'd4, v); chk("R5 zero count stays enabled", {31'd0, v[0]}, 1);
    wr(3'd4, 0);

    // R10 unsupported flow types
    for (int f = 4; f < 8; f++) begin
      setup(32'h40, 32'h100, 0, 32'd1);
      a0 = acc_n; e0 = err_n;
      wr(3'd4, 32'd1 | (32'(f) << 11));
      idle(10);
      chk("R10 err pulse", 32'(err_n - e0), 1);
      chk("R10 no access", 32'(acc_n - a0), 0);
      rd(3'd4, v); chk("R10 enable cleared", {31'd0, v[0]}, 0);
    end

    // R7 linked list
    mem[16] = 32'hC0DE_0001; mem[32] = 32'hC0DE_0002; mem[33] = 32'hC0DE_0003;
    mem[64] = 0; mem[80] = 0; mem[81] = 0;
    mem[192] = 32'h80; mem[193] = 32'h140; mem[194] = 32'h0;
    mem[195] = {1'b1, 3'b000, 2'b11, 2'b00, 3'd2, 3'd2, 6'd0, 12'd2};
    setup(32'h40, 32'h100, 32'h300, {1'b0, 7'd0, 3'd2, 3'd2, 6'd0, 12'd1});
    rn = 0; t0 = tc_n;
    wr(3'd4, 32'd1);
    wait_idle();
    idle(2);
    chk("R7 fetch order 0", rlog[1], 32'h300);
    chk("R7 fetch order 1", rlog[2], 32'h304);
    chk("R7 fetch order 2", rlog[3], 32'h30C);
    chk("R7 fetch order 3", rlog[4], 32'h308);
    rd(3'd2, v); chk("R7 next pointer loaded", v, 0);
    rd(3'd0, v); chk("R7 src after chain", v, 32'h88);
    rd(3'd1, v); chk("R7 dst after chain", v, 32'h148);
    chk("R7 first data", mem[64], 32'hC0DE_0001);
    chk("R7 chained data 0", mem[80], 32'hC0DE_0002);
    chk("R7 chained data 1", mem[81], 32'hC0DE_0003);
    chk("R9 tc only for finished word with bit31", 32'(tc_n - t0), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule